// File: doc/BRIEF.md
# Duplex-Aware Transmit Deferral Controller

This block decides when the transmit side of a 10/100 Ethernet MAC may start a frame. It watches the transmitter's own activity, the receive/carrier indication and the collision input. It enforces an inter-packet gap, counted in bit times on a bit-time tick. When a frame is waiting and the gap has run out, it raises a transmit-permit output. Backoff, preamble generation and the data path are handled elsewhere.

The rules depend on the duplex mode. In half duplex the controller defers to carrier and collisions, and the gap starts only once both the transmitter and the carrier have gone quiet. Right after each frame it opens a short window during which carrier sense is blinded. A collision pulse seen inside that window is reported as a passing SQE test, not as a collision. In full duplex it ignores carrier and collisions, starts the gap as soon as its own transmission ends, and never opens the window. The duplex input is sampled only while the transmitter is idle, so the rules in force never change under a frame in progress.

Top module: `txdefer_ctl`

## Requirements
- R1: Reset clears the gap count and closes the SQE window. With a frame pending, `tx_permit` first rises after GAP_BITS ticks with the line quiet.
- R2: `tx_permit` is high only while `frame_pend` is high, the gap count has reached GAP_BITS and the line is not busy.
- R3: The gap count advances only on clock edges where `bit_tick` is high.
- R4: In half duplex (`duplex_full`=0), the gap count is held at zero while `tx_active` or an unmasked `carrier` is high. Carrier seen after the gap has started restarts the count from zero.
- R5: In half duplex, the SQE window (`sqe_window`=1) opens on the edge where `tx_active` is seen to fall. It stays open for BLIND_BITS ticks, and `carrier` is ignored while it is open.
- R6: In half duplex, a collision inside the window gives `sqe_pass`=1 and `coll_det`=0. Outside the window it gives `coll_det`=1, and the line counts as busy, which restarts the gap.
- R7: In full duplex (`duplex_full`=1), `carrier` never defers transmission, and the gap count starts on the edge after `tx_active` falls.
- R8: In full duplex, the SQE window never opens, and `collision` has no effect on `coll_det`, `sqe_pass` or `tx_permit`.
- R9: The duplex mode is taken from `duplex_full` only on edges where `tx_active` is low. A frame that ends is governed by the mode it started in.
- R10: `tx_permit` is low whenever `tx_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time |
| tx_active | input | 1 | Transmitter is sending a frame |
| carrier | input | 1 | Receive/carrier-sense activity |
| collision | input | 1 | Collision indication from the line interface |
| frame_pend | input | 1 | A frame is waiting to be sent |
| duplex_full | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_permit | output | 1 | Transmission may start |
| sqe_window | output | 1 | Post-transmit blinding window is open |
| sqe_pass | output | 1 | Collision seen inside the window (SQE test pass) |
| coll_det | output | 1 | Collision seen outside the window, half duplex only |

## Verification
The bench walks the gap count tick by tick with a small gap and window. At every step it compares the permit against the number of quiet ticks it has applied. A design that counted clock edges instead of ticks, or that started the gap before the carrier dropped, would grant the permit too early. The bench holds carrier high throughout the blinding window and injects collisions on both sides of the window edge. A design that failed to mask carrier would restart the gap, and one that classified collisions wrongly would swap `sqe_pass` and `coll_det`. It also flips the duplex input in the middle of a frame. A design that let the new mode apply at once would open or suppress the window for the wrong frame.

// File: rtl/txdefer_pkg.sv
package txdefer_pkg;
   typedef enum logic {
      DPX_HALF = 1'b0,
      DPX_FULL = 1'b1
   } duplex_e;
endpackage

// File: rtl/txdefer_mode.sv
// Holds the duplex mode; follows the request only while the transmitter is idle.
module txdefer_mode
   import txdefer_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tx_active,
   input  logic    req_full,
   output duplex_e mode_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= DPX_HALF;
      else if (!tx_active)
         mode_q <= req_full ? DPX_FULL : DPX_HALF;
   end
endmodule

// File: rtl/txdefer_gap.sv
// Inter-packet gap counter: cleared while busy, advances on bit ticks.
module txdefer_gap #(
   parameter int GAP_BITS = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic busy,
   output logic gap_done
);
   localparam int CW = $clog2(GAP_BITS + 1);
   localparam logic [CW-1:0] GAP_END = CW'(GAP_BITS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (busy)
         cnt_q <= '0;
      else if (bit_tick && (cnt_q != GAP_END))
         cnt_q <= cnt_q + 1'b1;
   end

   assign gap_done = (cnt_q == GAP_END);
endmodule

// File: rtl/txdefer_blind.sv
// Post-transmit blinding window, armed on the falling edge of transmit activity.
module txdefer_blind #(
   parameter int BLIND_BITS = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic tx_active,
   input  logic arm,
   output logic window
);
   generate
      if (BLIND_BITS == 0) begin : g_none
         assign window = 1'b0;
      end else begin : g_timer
         localparam int BW = $clog2(BLIND_BITS + 1);
         localparam logic [BW-1:0] LOAD = BW'(BLIND_BITS);
         logic [BW-1:0] left_q;
         logic          tx_q;
         logic          tx_fell;

         assign tx_fell = tx_q & ~tx_active;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tx_q   <= 1'b0;
               left_q <= '0;
            end else begin
               tx_q <= tx_active;
               if (tx_fell && arm)
                  left_q <= LOAD;
               else if (bit_tick && (left_q != '0))
                  left_q <= left_q - 1'b1;
            end
         end

         assign window = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/txdefer_ctl.sv
module txdefer_ctl
   import txdefer_pkg::*;
#(
   parameter int GAP_BITS   = 96,
   parameter int BLIND_BITS = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic tx_active,
   input  logic carrier,
   input  logic collision,
   input  logic frame_pend,
   input  logic duplex_full,
   output logic tx_permit,
   output logic sqe_window,
   output logic sqe_pass,
   output logic coll_det
);
   generate
      if (GAP_BITS < 2) begin : g_bad_gap
         $error("txdefer_ctl: GAP_BITS must be at least 2");
      end
      if (BLIND_BITS < 0) begin : g_bad_blind
         $error("txdefer_ctl: BLIND_BITS must not be negative");
      end
   endgenerate

   duplex_e mode_q;
   logic    half;
   logic    mode_is_full;
   logic    carrier_seen;
   logic    coll_in;
   logic    busy;
   logic    gap_done;

   txdefer_mode u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_active (tx_active),
      .req_full  (duplex_full),
      .mode_q    (mode_q)
   );

   assign half         = (mode_q == DPX_HALF);
   assign mode_is_full = ~half;

   txdefer_blind #(.BLIND_BITS(BLIND_BITS)) u_blind (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .tx_active (tx_active),
      .arm       (half),
      .window    (sqe_window)
   );

   assign carrier_seen = half & ~sqe_window & carrier;
   assign coll_in      = half & collision;
   assign sqe_pass     = coll_in & sqe_window;
   assign coll_det     = coll_in & ~sqe_window;
   assign busy         = tx_active | carrier_seen | coll_det;

   txdefer_gap #(.GAP_BITS(GAP_BITS)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .busy     (busy),
      .gap_done (gap_done)
   );

   assign tx_permit = frame_pend & gap_done & ~busy;
endmodule

// File: rtl/txdefer_chk.sv
module txdefer_chk #(
   parameter int BLIND_BITS = 40
) (
   input logic clk,
   input logic rst_n,
   input logic tx_active,
   input logic frame_pend,
   input logic tx_permit,
   input logic sqe_window,
   input logic sqe_pass,
   input logic coll_det,
   input logic full_q
);
   p_permit_needs_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_permit |-> frame_pend);

   p_no_permit_in_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |-> !tx_permit);

   p_pass_inside_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sqe_pass |-> (sqe_window && !coll_det));

   p_full_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> (!sqe_pass && !coll_det));

   p_mode_held_in_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |=> (full_q == $past(full_q)));

   generate
      if (BLIND_BITS > 0) begin : g_win
         p_window_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(tx_active) && !tx_active && !full_q) |=> sqe_window);
      end
   endgenerate
endmodule

bind txdefer_ctl txdefer_chk #(.BLIND_BITS(BLIND_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_active  (tx_active),
   .frame_pend (frame_pend),
   .tx_permit  (tx_permit),
   .sqe_window (sqe_window),
   .sqe_pass   (sqe_pass),
   .coll_det   (coll_det),
   .full_q     (mode_is_full)
);

// File: tb/txdefer_ctl_bench.sv
module txdefer_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int GAP   = 12;
   localparam int BLIND = 5;

   logic clk = 1'b0;
   logic rst_n, bit_tick, tx_active, carrier, collision, frame_pend, duplex_full;
   logic tx_permit, sqe_window, sqe_pass, coll_det;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txdefer_ctl #(.GAP_BITS(GAP), .BLIND_BITS(BLIND)) u_txdefer_ctl (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_active(tx_active),
      .carrier(carrier), .collision(collision), .frame_pend(frame_pend),
      .duplex_full(duplex_full), .tx_permit(tx_permit), .sqe_window(sqe_window),
      .sqe_pass(sqe_pass), .coll_det(coll_det)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic act, input logic exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // counts quiet edges after the line goes idle and checks the permit each time
   task automatic gap_sweep(input int upto, input string tag);
      for (int n = 1; n <= upto; n++) begin
         step();
         chk(tx_permit, n >= GAP, tag);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      int ticks;
      rst_n = 1'b0; bit_tick = 1'b1; tx_active = 1'b0; carrier = 1'b0;
      collision = 1'b0; frame_pend = 1'b1; duplex_full = 1'b0;
      step(); step();
      chk(tx_permit, 1'b0, "R1 permit in reset");
      chk(sqe_window, 1'b0, "R1 window in reset");
      rst_n = 1'b1;
      gap_sweep(GAP + 2, "R1 first gap");

      frame_pend = 1'b0; step();
      chk(tx_permit, 1'b0, "R2 no frame pending");
      frame_pend = 1'b1;

      // half duplex frame, carrier held during blinding window
      tx_active = 1'b1; step();
      chk(tx_permit, 1'b0, "R10 permit during tx");
      step(); step();
      tx_active = 1'b0; step();
      chk(sqe_window, 1'b1, "R5 window opens");
      carrier = 1'b1; collision = 1'b1; #1;
      chk(sqe_pass, 1'b1, "R6 sqe pass in window");
      chk(coll_det, 1'b0, "R6 no collision in window");
      collision = 1'b0;
      for (int m = 2; m <= GAP + 2; m++) begin
         step();
         chk(sqe_window, m <= BLIND, "R5 window length");
         chk(tx_permit, m >= GAP, "R5 carrier masked in window");
         if (m == BLIND) carrier = 1'b0;
      end

      // collision outside the window
      collision = 1'b1; #1;
      chk(coll_det, 1'b1, "R6 collision outside window");
      chk(sqe_pass, 1'b0, "R6 no sqe pass outside window");
      step();
      collision = 1'b0;
      chk(tx_permit, 1'b0, "R6 collision restarts gap");
      gap_sweep(GAP + 1, "R6 gap after collision");

      // carrier restarts the gap in half duplex
      carrier = 1'b1; step(); step();
      chk(tx_permit, 1'b0, "R4 carrier defers");
      carrier = 1'b0;
      gap_sweep(6, "R4 partial gap");
      carrier = 1'b1; step();
      carrier = 1'b0;
      gap_sweep(GAP + 1, "R4 gap restarted");

      // ticks every third clock
      carrier = 1'b1; step(); carrier = 1'b0;
      ticks = 0;
      for (int c = 1; c <= 3 * GAP + 3; c++) begin
         bit_tick = (c % 3 == 0);
         if (bit_tick) ticks++;
         step();
         chk(tx_permit, ticks >= GAP, "R3 counts ticks only");
      end
      bit_tick = 1'b1;

      // full duplex
      duplex_full = 1'b1; step();
      carrier = 1'b1;
      tx_active = 1'b1; step(); step();
      tx_active = 1'b0;
      for (int m = 1; m <= GAP + 1; m++) begin
         step();
         chk(sqe_window, 1'b0, "R8 no window in full duplex");
         chk(tx_permit, m >= GAP, "R7 gap from tx end, carrier ignored");
      end
      collision = 1'b1; #1;
      chk(coll_det, 1'b0, "R8 collision ignored");
      chk(sqe_pass, 1'b0, "R8 no sqe pass");
      step();
      chk(tx_permit, 1'b1, "R8 collision does not defer");
      collision = 1'b0;

      // mode request during a full-duplex frame
      tx_active = 1'b1; step();
      duplex_full = 1'b0; step(); step();
      tx_active = 1'b0; step();
      chk(sqe_window, 1'b0, "R9 frame keeps full mode");
      for (int k = 0; k < GAP + 2; k++) step();
      chk(tx_permit, 1'b0, "R9 half mode applies after idle");
      carrier = 1'b0;
      gap_sweep(GAP + 1, "R9 gap in half mode");

      // mode request during a half-duplex frame
      tx_active = 1'b1; step();
      duplex_full = 1'b1; step();
      tx_active = 1'b0; step();
      chk(sqe_window, 1'b1, "R9 frame keeps half mode");

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule